// File: doc/BRIEF.md
# Phase-Interleaved Serial Shift Register

This block is a serial-in, serial-out delay line. From its pins it looks exactly like a plain chain of `DEPTH` flip-flops clocked every cycle. Inside, the chain is split into `PAR` banks of `DEPTH/PAR` stages each.

A phase counter runs at the full clock rate and gives each bank a one-hot enable once every `PAR` cycles. The arriving bit is written into the bank whose turn it is. An output multiplexer, steered by the same counter, picks the last stage of the bank that holds the oldest bit. The serial order is therefore rebuilt with no extra latency.

Each stage is clocked at a rate of f/`PAR`. Its switching activity falls in the same ratio while the supply stays unchanged. Banks are modelled with clock enables. Legal values of `PAR` are 1, 2 and 4, and `DEPTH` must be a multiple of `PAR`. The default is a 16-stage line split two ways.

Top module: `ilv_shift`

## Requirements
- R1: `dout` carries the `din` value that was sampled `DEPTH` rising edges earlier. With the first edge after reset release counted as edge 0, `dout` after edge k+`DEPTH`-1 equals the `din` value sampled at edge k.
- R2: While `rst_n` is low, and for the first `DEPTH`-1 cycles after release, `dout` reads 0, because every stored stage starts cleared.
- R3: Exactly one bit of `bank_en` is high in every cycle.
- R4: After reset, `bank_en` bit 0 is high. The high bit then moves one place upward (b to b+1, wrapping from `PAR`-1 to 0) on each rising edge. So in the cycle that follows m edges since release, bit (m mod `PAR`) is high.
- R5: Over any run of `PAR`·k consecutive cycles, each `bank_en` bit is high in exactly k cycles. Each bank therefore shifts at 1/`PAR` of the clock rate.
- R6: Pulling `rst_n` low in the middle of a stream takes effect at once. It discards all stored bits, forces `dout` to 0 and puts `bank_en` back to bit 0.
- R7: The serial output stream does not depend on `PAR`. Builds with `PAR` of 1, 2 and 4, given the same input, give the same `dout` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Serial data in, sampled on each rising edge |
| dout | output | 1 | Serial data out, delayed by `DEPTH` edges |
| bank_en | output | PAR | One-hot bank capture enable, with bit b for bank b |

## Verification
The bench drives the same stream into three builds (`PAR` = 2, 4 and 1) and compares each against a history of sampled bits, checking every cycle. It targets a lone 1 in a field of zeros and alternating bits. A wrong bank rotation or an off-by-one in the output select would emit those bits in a shuffled order or one cycle early or late, which a uniform stream would hide. It also checks the first `DEPTH` cycles after release. A bank that is not cleared, or a phase counter that does not restart at bank 0, would leak stale bits into that window. A reset pulled mid-stream must land the design back in that same clean state.

// File: rtl/ilv_shift.sv
module ilv_shift #(
  parameter int DEPTH = 16,
  parameter int PAR   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din,
  output logic           dout,
  output logic [PAR-1:0] bank_en
);
  localparam int SEG = DEPTH / PAR;
  localparam int PW  = (PAR > 1) ? $clog2(PAR) : 1;
  localparam logic [PW-1:0] LAST = PW'(PAR - 1);

  logic [PW-1:0]  phase;
  logic [PAR-1:0] tap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              phase <= '0;
    else if (phase == LAST)  phase <= '0;
    else                     phase <= phase + 1'b1;

  for (genvar b = 0; b < PAR; b++) begin : g_bank
    logic [SEG-1:0] st;
    assign bank_en[b] = (phase == PW'(b));
    if (SEG > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)          st <= '0;
        else if (bank_en[b]) st <= {st[SEG-2:0], din};
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)          st <= '0;
        else if (bank_en[b]) st <= din;
    end
    assign tap[b] = st[SEG-1];
  end

  if (PAR > 1) begin : g_mux
    assign dout = tap[phase];
  end else begin : g_direct
    assign dout = tap[0];
  end
endmodule

// File: rtl/ilv_shift_chk.sv
module ilv_shift_chk #(
  parameter int DEPTH = 16,
  parameter int PAR   = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           din,
  input logic           dout,
  input logic [PAR-1:0] bank_en
);
  logic [DEPTH-1:0] line;
  logic             fresh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      line  <= '0;
      fresh <= 1'b1;
    end else begin
      line  <= {line[DEPTH-2:0], din};
      fresh <= 1'b0;
    end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dout == line[DEPTH-1]);

  assert_clean_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |-> (!dout && bank_en == PAR'(1)));

  assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_en) == 1);

  for (genvar b = 0; b < PAR; b++) begin : g_rot
    assert_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bank_en[b] |=> bank_en[(b + 1) % PAR]);
  end
endmodule

bind ilv_shift ilv_shift_chk #(.DEPTH(DEPTH), .PAR(PAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .dout(dout), .bank_en(bank_en)
);

// File: tb/sim_ilv_shift.sv
`timescale 1ns/1ps
module sim_ilv_shift;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic d2, d4, d1;
  logic [1:0] e2;
  logic [3:0] e4;
  logic [0:0] e1;

  int checks = 0;
  int failures = 0;
  int n = 0;
  logic hist[$];
  int hi2[2];
  int hi4[4];
  int hi1[1];

  always #2.5 clk = ~clk;

  ilv_shift #(.DEPTH(DEPTH), .PAR(2)) u0 (.clk(clk), .rst_n(rst_n), .din(din), .dout(d2), .bank_en(e2));
  ilv_shift #(.DEPTH(DEPTH), .PAR(4)) u1 (.clk(clk), .rst_n(rst_n), .din(din), .dout(d4), .bank_en(e4));
  ilv_shift #(.DEPTH(DEPTH), .PAR(1)) u2 (.clk(clk), .rst_n(rst_n), .din(din), .dout(d1), .bank_en(e1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, n);
    end
  endtask

  function automatic logic exp_out();
    if (n < DEPTH) return 1'b0;
    return hist[n - DEPTH];
  endfunction

  task automatic check_cycle();
    logic e;
    string tag;
    e = exp_out();
    tag = (n < DEPTH) ? "R2" : "R1";
    chk(d2 == e, {tag, " dout PAR=2"}, d2, e);
    chk(d4 == e, {tag, " dout PAR=4"}, d4, e);
    chk(d1 == e, {tag, " R7 dout PAR=1"}, d1, e);
    chk(d2 == d4 && d4 == d1, "R7 builds agree", {d2, d4, d1}, {e, e, e});
    chk($countones(e2) == 1 && $countones(e4) == 1 && e1 == 1'b1, "R3 one bank", {e4, e2}, 0);
    chk(e2 == 2'(1 << (n % 2)), "R4 bank_en PAR=2", e2, 1 << (n % 2));
    chk(e4 == 4'(1 << (n % 4)), "R4 bank_en PAR=4", e4, 1 << (n % 4));
    for (int b = 0; b < 2; b++) hi2[b] += e2[b];
    for (int b = 0; b < 4; b++) hi4[b] += e4[b];
    hi1[0] += e1[0];
  endtask

  task automatic step(input logic v);
    din = v;
    @(posedge clk);
    hist.push_back(din);
    n++;
    @(negedge clk);
    check_cycle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    din = 1'b0;
    #1;
    chk(d2 == 1'b0 && d4 == 1'b0 && d1 == 1'b0, "R6 reset clears dout", {d2, d4, d1}, 0);
    chk(e2 == 2'b01 && e4 == 4'b0001 && e1 == 1'b1, "R6 reset bank 0", {e4, e2}, 'b000101);
    @(negedge clk);
    @(negedge clk);
    chk(d2 == 1'b0 && d4 == 1'b0 && d1 == 1'b0, "R2 dout in reset", {d2, d4, d1}, 0);
    hist.delete();
    n = 0;
    rst_n = 1'b1;
    check_cycle();
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired at cycle %0d", n);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < 40; i++) step(1'b0);
    step(1'b1);
    for (int i = 0; i < 40; i++) step(1'b0);
    for (int i = 0; i < 48; i++) step(1'(i & 1));
    for (int i = 0; i < 48; i++) step(1'(((i >> 1) ^ (i >> 3)) & 1));
    for (int i = 0; i < 32; i++) step(1'b1);
    for (int i = 0; i < 400; i++) step(1'($urandom & 1));
    for (int b = 0; b < 2; b++) hi2[b] = 0;
    for (int b = 0; b < 4; b++) hi4[b] = 0;
    hi1[0] = 0;
    for (int i = 0; i < 400; i++) step(1'($urandom & 1));
    for (int b = 0; b < 2; b++) chk(hi2[b] == 200, "R5 PAR=2 bank activity", hi2[b], 200);
    for (int b = 0; b < 4; b++) chk(hi4[b] == 100, "R5 PAR=4 bank activity", hi4[b], 100);
    chk(hi1[0] == 400, "R5 PAR=1 bank activity", hi1[0], 400);
    for (int i = 0; i < 7; i++) step(1'b1);
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b1);
    step(1'b0);
    for (int i = 0; i < 60; i++) step(1'($urandom & 1));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule